// File: doc/BRIEF.md
# Drive Status/Command Nibble Link Controller

This block sits on the host side of a narrow 4-bit link to an optical-drive controller. It keeps two banks of ten 4-bit words: a status bank that only the link fills in and the host can only read, and a command bank that the host writes one word per byte address. When the drive pulls its active-low request line, the controller collects ten status nibbles from it over a HOCK/CDCK handshake. When the host writes the last command word, the controller sends the ten command nibbles back to the drive over the same handshake.

Two busy flags show when a receive or a send is in progress. A sticky interrupt request is raised part way through a receive, after the eighth status nibble. This gives the host's handler time to start, and the last two words are in place before the handler reads them. The host writes a control word to arm reception and to clear the interrupt.

Top module: `nibble_link_ctrl`

## Requirements
- R1: After reset every status and command word reads 0, the control word reads 0, and `hock_o`, `drs_o`, `dts_o` and `irq_o` are low.
- R2: Host writes to status addresses 0..9 have no effect; the status words change only when the link stores a received nibble.
- R3: Each command word at address 10+k (k = 0..9) is written on its own by a single write of its low 4 bits and reads back the written value.
- R4: Writing command words 10..18 never starts a send: `hock_o` and `dts_o` stay low.
- R5: A falling edge on `drv_irq_ni` starts a receive only while receive-enable (control address 20, bit 0) is 1. An edge seen while it is 0 is remembered, and the receive starts once the bit is set.
- R6: While `hock_o` is high, a cycle with `drv_cdck_i` high completes one nibble transfer, and `hock_o` is low in the next cycle. `hock_o` rises again for the next nibble only after `drv_cdck_i` has been seen low. Received nibbles go into status words 0..9 in arrival order.
- R7: `drs_o` (control bit 2) is high from the start of a receive until the tenth status nibble has been stored, and is low in the cycle after that store.
- R8: The interrupt request `irq_o` rises in the cycle after the eighth status nibble is stored, and it is already high when the drive is asked for the ninth nibble.
- R9: `irq_o` (control bit 3) stays high until the host writes control address 20 with bit 3 set.
- R10: A write to command address 19 starts a send. `dts_o` (control bit 1) goes high, command words 0..9 are placed on `link_data_o` in order, each while `hock_o` is high, and each later word is placed only after the drive's CDCK for the one before.
- R11: After the drive acknowledges the tenth command nibble, `dts_o` is low in the next cycle and the link stays idle until a new request edge arrives.
- R12: A write to command address 19 during a receive or a send is held. Exactly one send of the then-current command words follows once the link goes idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Host write strobe |
| bus_addr_i | input | 5 | Host address: 0..9 status, 10..19 command, 20 control |
| bus_wdata_i | input | 4 | Host write data |
| bus_rdata_o | output | 4 | Host read data for `bus_addr_i` (control: {irq, drs, dts, rx_en}) |
| drv_irq_ni | input | 1 | Drive request, active low |
| drv_cdck_i | input | 1 | Drive strobe for each nibble |
| drv_data_i | input | 4 | Status nibble from the drive |
| hock_o | output | 1 | Controller handshake strobe |
| link_data_o | output | 4 | Command nibble to the drive |
| drs_o | output | 1 | Receive in progress |
| dts_o | output | 1 | Send in progress |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
A nibble index that is out of step shows up at the ports within one frame. The received words land in the wrong status addresses, the command words come out on `link_data_o` in the wrong order, or the interrupt rises at some nibble other than the eighth. Each of these is seen on the very nibble where it goes wrong, because the bench compares every handshake. A handshake state that is out of step shows within a cycle or two: `hock_o` fails to drop after CDCK, or it rises again while CDCK is still high. A lost or duplicated queued send shows as a missing frame or an extra frame of HOCK pulses after a receive or a send.

// File: rtl/nlc_pkg.sv
package nlc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_REQ,
    ST_RX_GAP,
    ST_TX_REQ,
    ST_TX_GAP
  } link_st_e;
endpackage

// File: rtl/nlc_link_fsm.sv
module nlc_link_fsm
  import nlc_pkg::*;
#(
  parameter int unsigned NIBBLES = 10,
  localparam int unsigned IDX_W = $clog2(NIBBLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             tx_start_i,
  input  logic             drv_irq_ni,
  input  logic             cdck_i,
  output logic             hock_o,
  output logic             rx_store_o,
  output logic             tx_drive_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             drs_o,
  output logic             dts_o
);
  link_st_e st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic irq_q, irq_seen_q, tx_pend_q, drs_q, dts_q;
  logic fell, idle, last, start_tx, start_rx, tx_sent;

  assign fell     = irq_q & ~drv_irq_ni;
  assign idle     = (st_q == ST_IDLE);
  assign last     = (idx_q == IDX_W'(NIBBLES-1));
  // a queued send wins over a pending receive
  assign start_tx = idle & (tx_pend_q | tx_start_i);
  assign start_rx = idle & ~start_tx & rx_en_i & (irq_seen_q | fell);
  assign tx_sent  = (st_q == ST_TX_REQ) & cdck_i;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: begin
        idx_d = '0;
        if (start_tx)      st_d = ST_TX_REQ;
        else if (start_rx) st_d = ST_RX_REQ;
      end
      ST_RX_REQ: if (cdck_i) st_d = ST_RX_GAP;
      ST_RX_GAP: if (!cdck_i) begin
        if (last) st_d = ST_IDLE;
        else begin
          st_d  = ST_RX_REQ;
          idx_d = idx_q + 1'b1;
        end
      end
      ST_TX_REQ: if (cdck_i) st_d = ST_TX_GAP;
      ST_TX_GAP: if (!cdck_i) begin
        if (last) st_d = ST_IDLE;
        else begin
          st_d  = ST_TX_REQ;
          idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      idx_q      <= '0;
      irq_q      <= 1'b1;
      irq_seen_q <= 1'b0;
      tx_pend_q  <= 1'b0;
      drs_q      <= 1'b0;
      dts_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      idx_q      <= idx_d;
      irq_q      <= drv_irq_ni;
      irq_seen_q <= (irq_seen_q | fell) & ~start_rx;
      tx_pend_q  <= (tx_pend_q | tx_start_i) & ~start_tx;
      if (start_rx)               drs_q <= 1'b1;
      else if (rx_store_o & last) drs_q <= 1'b0;
      if (start_tx)               dts_q <= 1'b1;
      else if (tx_sent & last)    dts_q <= 1'b0;
    end
  end

  assign hock_o     = (st_q == ST_RX_REQ) | (st_q == ST_TX_REQ);
  assign rx_store_o = (st_q == ST_RX_REQ) & cdck_i;
  assign tx_drive_o = (st_q == ST_TX_REQ);
  assign idx_o      = idx_q;
  assign drs_o      = drs_q;
  assign dts_o      = dts_q;

  p_hock_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hock_o && cdck_i |=> !hock_o);
  p_no_rehock_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hock_o && cdck_i |=> !hock_o);
  p_rx_gated_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && !rx_en_i && !tx_pend_q && !tx_start_i |=> !hock_o);
  p_drs_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_store_o && last |=> !drs_o);
  p_dts_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sent && last |=> !dts_o);
  p_flags_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({drs_o, dts_o}));
  p_queued_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i && !idle |=> tx_pend_q || dts_o);
endmodule

// File: rtl/nlc_regs.sv
module nlc_regs #(
  parameter int unsigned NIBBLES = 10,
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned IDX_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NIB_W-1:0]  bus_wdata_i,
  output logic [NIB_W-1:0]  bus_rdata_o,
  input  logic              rx_we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [NIB_W-1:0]  rx_data_i,
  input  logic              drs_i,
  input  logic              dts_i,
  input  logic              irq_i,
  output logic              rx_en_o,
  output logic              cmd_last_wr_o,
  output logic              irq_clr_o,
  output logic [NIB_W-1:0]  tx_nib_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2*NIBBLES);
  localparam logic [ADDR_W-1:0] LAST_CMD  = ADDR_W'(2*NIBBLES-1);

  logic [NIBBLES-1:0][NIB_W-1:0] status_q, cmd_q;
  logic rx_en_q;
  logic ctrl_wr;

  for (genvar g = 0; g < NIBBLES; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q[g] <= '0;
      else if (rx_we_i && idx_i == IDX_W'(g)) status_q[g] <= rx_data_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmd_q[g] <= '0;
      else if (bus_we_i && bus_addr_i == ADDR_W'(NIBBLES+g)) cmd_q[g] <= bus_wdata_i;
    end
  end

  assign ctrl_wr = bus_we_i && bus_addr_i == CTRL_ADDR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rx_en_q <= 1'b0;
    else if (ctrl_wr) rx_en_q <= bus_wdata_i[0];
  end

  assign rx_en_o       = rx_en_q;
  assign irq_clr_o     = ctrl_wr & bus_wdata_i[3];
  assign cmd_last_wr_o = bus_we_i && bus_addr_i == LAST_CMD;

  always_comb begin
    bus_rdata_o = '0;
    tx_nib_o    = '0;
    for (int i = 0; i < NIBBLES; i++) begin
      if (bus_addr_i == ADDR_W'(i))         bus_rdata_o = status_q[i];
      if (bus_addr_i == ADDR_W'(NIBBLES+i)) bus_rdata_o = cmd_q[i];
      if (idx_i == IDX_W'(i))               tx_nib_o    = cmd_q[i];
    end
    if (bus_addr_i == CTRL_ADDR) bus_rdata_o = NIB_W'({irq_i, drs_i, dts_i, rx_en_q});
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata_i;

  p_status_ro_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_we_i |=> $stable(status_q));
  p_cmd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i >= ADDR_W'(NIBBLES) && bus_addr_i < CTRL_ADDR)
    |=> $stable(cmd_q));
endmodule

// File: rtl/nlc_irq.sv
module nlc_irq #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned IRQ_AT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_store_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             clr_i,
  output logic             irq_o
);
  logic pend_q, hit;

  assign hit = rx_store_i && idx_i == IDX_W'(IRQ_AT-1);

  // a new hit wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (hit)   pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign irq_o = pend_q;

  p_irq_at_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> irq_o);
  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i |=> irq_o);
endmodule

// File: rtl/nibble_link_ctrl.sv
module nibble_link_ctrl #(
  parameter int unsigned NIBBLES = 10,
  parameter int unsigned NIB_W   = 4,
  parameter int unsigned IRQ_AT  = 8,
  localparam int unsigned ADDR_W = $clog2(2*NIBBLES+1),
  localparam int unsigned IDX_W  = $clog2(NIBBLES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NIB_W-1:0]  bus_wdata_i,
  output logic [NIB_W-1:0]  bus_rdata_o,
  input  logic              drv_irq_ni,
  input  logic              drv_cdck_i,
  input  logic [NIB_W-1:0]  drv_data_i,
  output logic              hock_o,
  output logic [NIB_W-1:0]  link_data_o,
  output logic              drs_o,
  output logic              dts_o,
  output logic              irq_o
);
  logic rx_en, cmd_last_wr, irq_clr, rx_store, tx_drive;
  logic [IDX_W-1:0] idx;
  logic [NIB_W-1:0] tx_nib;

  nlc_link_fsm #(.NIBBLES(NIBBLES)) i_fsm (
    .clk_i, .rst_ni,
    .rx_en_i    (rx_en),
    .tx_start_i (cmd_last_wr),
    .drv_irq_ni,
    .cdck_i     (drv_cdck_i),
    .hock_o,
    .rx_store_o (rx_store),
    .tx_drive_o (tx_drive),
    .idx_o      (idx),
    .drs_o,
    .dts_o
  );

  nlc_regs #(.NIBBLES(NIBBLES), .NIB_W(NIB_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_regs (
    .clk_i, .rst_ni,
    .bus_we_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .rx_we_i       (rx_store),
    .idx_i         (idx),
    .rx_data_i     (drv_data_i),
    .drs_i         (drs_o),
    .dts_i         (dts_o),
    .irq_i         (irq_o),
    .rx_en_o       (rx_en),
    .cmd_last_wr_o (cmd_last_wr),
    .irq_clr_o     (irq_clr),
    .tx_nib_o      (tx_nib)
  );

  nlc_irq #(.IDX_W(IDX_W), .IRQ_AT(IRQ_AT)) i_irq (
    .clk_i, .rst_ni,
    .rx_store_i (rx_store),
    .idx_i      (idx),
    .clr_i      (irq_clr),
    .irq_o
  );

  assign link_data_o = tx_drive ? tx_nib : '0;
endmodule

// File: tb/test_nibble_link_ctrl.sv
module test_nibble_link_ctrl;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic bus_we_i = 1'b0;
  logic [4:0] bus_addr_i = '0;
  logic [3:0] bus_wdata_i = '0, bus_rdata_o;
  logic drv_irq_ni = 1'b1, drv_cdck_i = 1'b0;
  logic [3:0] drv_data_i = '0, link_data_o;
  logic hock_o, drs_o, dts_o, irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] cmd_exp [10];

  always #10 clk_i = ~clk_i;

  nibble_link_ctrl i_nibble_link_ctrl (.*);

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk_i);
    bus_we_i = 1'b1; bus_addr_i = 5'(a); bus_wdata_i = 4'(d);
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(int a, output logic [3:0] v);
    @(negedge clk_i);
    bus_addr_i = 5'(a);
    #1 v = bus_rdata_o;
  endtask

  function automatic logic [3:0] spat(int r, int k); return 4'(k*7 + r*3 + 1); endfunction
  function automatic logic [3:0] cpat(int r, int k); return 4'(k*5 + r*11 + 2); endfunction

  // drive side of one status frame; qpos>=0 writes command 19 at that nibble
  task automatic rx_frame(int r, int qpos);
    logic [3:0] v;
    @(negedge clk_i);
    drv_irq_ni = 1'b0;
    for (int k = 0; k < 10; k++) begin
      while (!hock_o) @(negedge clk_i);
      chk("R7 drs during receive", drs_o, 1);
      if (k == 7) chk("R8 irq low before 8th", irq_o, 0);
      if (k == 8) chk("R8 irq high before 9th", irq_o, 1);
      drv_data_i = spat(r, k);
      drv_cdck_i = 1'b1;
      if (k == qpos) begin
        bus_we_i = 1'b1; bus_addr_i = 5'd19; bus_wdata_i = cmd_exp[9];
      end
      @(negedge clk_i);
      bus_we_i = 1'b0;
      chk("R6 hock drops after cdck", hock_o, 0);
      drv_cdck_i = 1'b0;
    end
    chk("R7 drs clear after 10th", drs_o, 0);
    drv_irq_ni = 1'b1;
    for (int k = 0; k < 10; k++) begin
      rd(k, v);
      chk("R6 status word order", v, spat(r, k));
    end
  endtask

  task automatic tx_frame(int qpos);
    for (int k = 0; k < 10; k++) begin
      while (!hock_o) @(negedge clk_i);
      chk("R10 dts during send", dts_o, 1);
      chk("R10 command nibble", link_data_o, cmd_exp[k]);
      drv_cdck_i = 1'b1;
      if (k == qpos) begin
        bus_we_i = 1'b1; bus_addr_i = 5'd19; bus_wdata_i = cmd_exp[9];
      end
      @(negedge clk_i);
      bus_we_i = 1'b0;
      chk("R6 hock drops after cdck", hock_o, 0);
      drv_cdck_i = 1'b0;
    end
    chk("R11 dts clear after 10th", dts_o, 0);
  endtask

  task automatic idle_check(string req, int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      chk(req, {hock_o, dts_o, drs_o}, 0);
    end
  endtask

  initial begin
    logic [3:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int a = 0; a <= 20; a++) begin
      rd(a, v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 reset pins", {hock_o, drs_o, dts_o, irq_o}, 0);
    // R2 status not writable
    for (int a = 0; a < 10; a++) begin
      wr(a, 4'hf);
      rd(a, v);
      chk("R2 status write ignored", v, 0);
    end
    // R5 request while disabled is held off, then served
    @(negedge clk_i);
    drv_irq_ni = 1'b0;
    idle_check("R5 no hock while disabled", 6);
    wr(20, 1);
    rd(20, v);
    chk("R5 rx_en readback", v[0], 1);
    rx_frame(0, -1);
    rd(20, v);
    chk("R9 irq sticky", v[3], 1);
    idle_check("R9 idle wait", 4);
    chk("R9 irq still high", irq_o, 1);
    wr(20, 4'h9);
    chk("R9 irq cleared", irq_o, 0);

    for (int r = 1; r <= 8; r++) begin
      for (int k = 0; k < 9; k++) begin
        cmd_exp[k] = cpat(r, k);
        wr(10 + k, cmd_exp[k]);
        @(negedge clk_i);
        chk("R4 no send on early word", {hock_o, dts_o}, 0);
      end
      for (int k = 0; k < 9; k++) begin
        rd(10 + k, v);
        chk("R3 command readback", v, cmd_exp[k]);
      end
      cmd_exp[9] = cpat(r, 9);
      wr(19, cmd_exp[9]);
      tx_frame(-1);
      idle_check("R11 idle until edge", 5);
      rx_frame(r, -1);
      wr(3, ~spat(r, 3));
      rd(3, v);
      chk("R2 status write ignored", v, spat(r, 3));
      wr(20, 4'h9);
      chk("R9 irq cleared", irq_o, 0);
    end

    // R12 write during receive queued
    rx_frame(9, 4);
    wr(20, 4'h9);
    tx_frame(-1);
    idle_check("R12 single send after receive", 5);
    // R12 write during send queued
    wr(19, cmd_exp[9]);
    tx_frame(3);
    tx_frame(-1);
    idle_check("R12 single send after send", 5);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule